// File: doc/BRIEF.md
# Load Delay Slot Hazard Classifier

This block sits beside a pipeline that has just issued a load and is about to run the instruction that follows it, the delay-slot instruction. It compares the load's target register with the fields of that 32-bit instruction word. From this it derives a 2-bit interaction class: no overlap, the slot instruction reads and also writes the target, it only reads it, or it only writes it. The decision is purely combinational and is visible on `hz_class` at all times.

When the pipeline raises `ld_valid`, a small sequencer latches the target register, the loaded value and the class, and then orders two events: the register-file write of the loaded value and the execution of the slot instruction. The slot instruction is started through a request/done handshake. If the slot instruction only reads the target, it runs first so that it sees the old contents, and the loaded value is written afterwards. If it both reads and writes the target, the loaded value is dropped. In every other case the loaded value is written first and the slot instruction runs next. The executing datapath and the register file remain outside this block.

Top module: `ldslot_hazard_unit`

## Requirements
- R1: A target register number of 0 always yields class 0, whatever the instruction word.
- R2: An instruction word of all zeros always yields class 0.
- R3: Class codes: 1 = the slot instruction reads and writes the target, 2 = it only reads it, 3 = it only writes it, 0 = neither. Read-and-write takes precedence over read, and read over write. Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0].
- R4: For opcode 0x00, these function codes behave as follows. Function 0x20–0x27, 0x2A, 0x2B, 0x04, 0x06 and 0x07 read rs and rt and write rd. Function 0x00, 0x02 and 0x03 read only rt and write rd, and the rs field is ignored. Function 0x08 reads rs. Function 0x09 reads rs and writes rd. Function 0x10 and 0x12 write rd. Function 0x11 and 0x13 read rs. Function 0x18–0x1B read rs and rt.
- R5: Opcodes 0x08–0x0E and 0x20, 0x21, 0x23, 0x24, 0x25 read rs and write rt. Opcode 0x0F writes only rt. Opcode 0x03 writes register 31.
- R6: Opcodes 0x22 and 0x26 give class 3 whenever rt matches, even when rs matches too. They give class 2 when only rs matches.
- R7: The following are reads only. Opcodes 0x28, 0x29, 0x2A, 0x2B, 0x2E, 0x04 and 0x05 read rs and rt. Opcodes 0x06, 0x07, 0x32 and 0x3A read rs. Opcode 0x01 with rt field 0x00, 0x01, 0x10 or 0x11 reads rs.
- R8: Opcodes 0x10 and 0x12 with bit 25 clear are coprocessor moves, decoded by the rs field. Rs field 0x00 or 0x02 writes rt, and 0x04 or 0x06 reads rt. With bit 25 set, these opcodes give class 0.
- R9: For an accepted load of class 0 or 3, `rf_we` is high for the single cycle after acceptance with the latched target and data. `slot_req` then rises in the following cycle and stays high until `slot_done`. `rf_we` and `slot_req` are never high together.
- R10: For an accepted load of class 2, `slot_req` rises in the cycle after acceptance with no write. The cycle after the `slot_done` handshake carries a one-cycle `rf_we` with the latched load data.
- R11: For an accepted load of class 1, `slot_req` rises in the cycle after acceptance. After `slot_done` the block returns idle without any write.
- R12: While `busy` is high, `ld_valid` is ignored. A pending write keeps the target and data latched at acceptance.
- R13: `rf_we` is never asserted for register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load is ready to retire; accepted when idle |
| ld_tgt | input | 5 | Target register of the load |
| ld_data | input | DATA_W | Value returned by the load |
| slot_insn | input | 32 | Instruction word in the delay slot |
| slot_done | input | 1 | Datapath has finished the slot instruction |
| hz_class | output | 2 | Combinational interaction class |
| slot_req | output | 1 | Request to execute the slot instruction |
| rf_we | output | 1 | Register-file write strobe for the loaded value |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | DATA_W | Register-file write data |
| busy | output | 1 | A sequence is in progress |

## Verification
The class is combinational, so it is checked one time step after the target and word are driven, in the same cycle. In the sequencer, each action appears one register stage after the edge that causes it. The write or the slot request is due in the first cycle after the accepting edge. The handshake-driven write in the read-only case lands one cycle after the edge that sees `slot_done`, and `busy` falls one cycle after the last action. The bench drives inputs just after a rising edge, then samples outputs after the next rising edge in exactly those cycles. It also checks the cycles in between for the absence of writes and requests.

// File: rtl/ldh_pkg.sv
package ldh_pkg;

  localparam int INSN_W = 32;
  localparam int REG_W  = 5;
  localparam int OP_W   = 6;

  typedef enum logic [1:0] {
    HZ_NONE = 2'd0,
    HZ_RW   = 2'd1,
    HZ_RD   = 2'd2,
    HZ_WR   = 2'd3
  } hz_class_e;

  // Which operand fields an instruction reads or defines.
  typedef struct packed {
    logic use_rs;
    logic use_rt;
    logic def_rd;
    logic def_rt;
    logic def_ra;    // writes the link register
    logic merge_rt;  // partial load: defining rt dominates
  } opnd_use_t;

  function automatic logic [REG_W-1:0] f_rs(input logic [INSN_W-1:0] w);
    return w[25:21];
  endfunction

  function automatic logic [REG_W-1:0] f_rt(input logic [INSN_W-1:0] w);
    return w[20:16];
  endfunction

  function automatic logic [REG_W-1:0] f_rd(input logic [INSN_W-1:0] w);
    return w[15:11];
  endfunction

  function automatic opnd_use_t decode_use(input logic [INSN_W-1:0] w);
    opnd_use_t u;
    logic [OP_W-1:0] op;
    logic [OP_W-1:0] fn;
    u  = '0;
    op = w[31:26];
    fn = w[5:0];
    case (op)
      6'h00: begin
        case (fn)
          6'h00, 6'h02, 6'h03: begin u.use_rt = 1'b1; u.def_rd = 1'b1; end
          6'h04, 6'h06, 6'h07,
          6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
          6'h2A, 6'h2B: begin
            u.use_rs = 1'b1; u.use_rt = 1'b1; u.def_rd = 1'b1;
          end
          6'h08:               u.use_rs = 1'b1;
          6'h09:               begin u.use_rs = 1'b1; u.def_rd = 1'b1; end
          6'h10, 6'h12:        u.def_rd = 1'b1;
          6'h11, 6'h13:        u.use_rs = 1'b1;
          6'h18, 6'h19, 6'h1A, 6'h1B: begin u.use_rs = 1'b1; u.use_rt = 1'b1; end
          default: ;
        endcase
      end
      6'h01: begin
        if (w[20:16] == 5'h00 || w[20:16] == 5'h01 ||
            w[20:16] == 5'h10 || w[20:16] == 5'h11)
          u.use_rs = 1'b1;
      end
      6'h03:               u.def_ra = 1'b1;
      6'h04, 6'h05:        begin u.use_rs = 1'b1; u.use_rt = 1'b1; end
      6'h06, 6'h07:        u.use_rs = 1'b1;
      6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E:
                           begin u.use_rs = 1'b1; u.def_rt = 1'b1; end
      6'h0F:               u.def_rt = 1'b1;
      6'h10, 6'h12: begin
        if (!w[25]) begin
          case (w[25:21])
            5'h00, 5'h02: u.def_rt = 1'b1;
            5'h04, 5'h06: u.use_rt = 1'b1;
            default: ;
          endcase
        end
      end
      6'h20, 6'h21, 6'h23, 6'h24, 6'h25:
                           begin u.use_rs = 1'b1; u.def_rt = 1'b1; end
      6'h22, 6'h26: begin
        u.use_rs = 1'b1; u.def_rt = 1'b1; u.merge_rt = 1'b1;
      end
      6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2E:
                           begin u.use_rs = 1'b1; u.use_rt = 1'b1; end
      6'h32, 6'h3A:        u.use_rs = 1'b1;
      default: ;
    endcase
    return u;
  endfunction

  // Fold read/write hits into a class; merge-type write wins over read.
  function automatic hz_class_e fold_class(input logic rd_hit, input logic wr_hit,
                                           input logic merge_hit);
    if (merge_hit)            return HZ_WR;
    else if (rd_hit && wr_hit) return HZ_RW;
    else if (rd_hit)          return HZ_RD;
    else if (wr_hit)          return HZ_WR;
    else                      return HZ_NONE;
  endfunction

endpackage

// File: rtl/ldh_classify.sv
module ldh_classify
  import ldh_pkg::*;
(
  input  logic [REG_W-1:0]  tgt,
  input  logic [INSN_W-1:0] insn,
  output hz_class_e         cls
);

  localparam logic [REG_W-1:0] LINK_REG = REG_W'(31);

  opnd_use_t use_w;
  logic      rs_read_hit;
  logic      rt_read_hit;
  logic      rd_write_hit;
  logic      rt_write_hit;
  logic      ra_write_hit;
  logic      any_read_hit;
  logic      any_write_hit;
  logic      merge_hit;
  logic      suppress;

  assign use_w         = decode_use(insn);
  assign rs_read_hit   = use_w.use_rs && (f_rs(insn) == tgt);
  assign rt_read_hit   = use_w.use_rt && (f_rt(insn) == tgt);
  assign rd_write_hit  = use_w.def_rd && (f_rd(insn) == tgt);
  assign rt_write_hit  = use_w.def_rt && (f_rt(insn) == tgt);
  assign ra_write_hit  = use_w.def_ra && (tgt == LINK_REG);
  assign any_read_hit  = rs_read_hit | rt_read_hit;
  assign any_write_hit = rd_write_hit | rt_write_hit | ra_write_hit;
  assign merge_hit     = use_w.merge_rt && rt_write_hit;
  assign suppress      = (tgt == '0) || (insn == '0);

  always_comb begin
    if (suppress) cls = HZ_NONE;
    else          cls = fold_class(any_read_hit, any_write_hit, merge_hit);
  end

endmodule

// File: rtl/ldh_sequencer.sv
module ldh_sequencer
  import ldh_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [REG_W-1:0]  ld_tgt,
  input  logic [DATA_W-1:0] ld_data,
  input  hz_class_e         cls,
  input  logic              slot_done,
  output logic              slot_req,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              busy
);

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_WR_PRE  = 2'd1,
    SQ_EXEC    = 2'd2,
    SQ_WR_POST = 2'd3
  } sq_state_e;

  sq_state_e         state_q;
  logic [REG_W-1:0]  tgt_q;
  logic [DATA_W-1:0] data_q;
  logic              post_q;

  logic accept;
  logic exec_end;
  logic write_slot;

  assign accept     = ld_valid && (state_q == SQ_IDLE);
  assign exec_end   = (state_q == SQ_EXEC) && slot_done;
  assign write_slot = (state_q == SQ_WR_PRE) || (state_q == SQ_WR_POST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      tgt_q   <= '0;
      data_q  <= '0;
      post_q  <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (accept) begin
            tgt_q  <= ld_tgt;
            data_q <= ld_data;
            case (cls)
              HZ_RD:   begin state_q <= SQ_EXEC;   post_q <= 1'b1; end
              HZ_RW:   begin state_q <= SQ_EXEC;   post_q <= 1'b0; end
              default: begin state_q <= SQ_WR_PRE; post_q <= 1'b0; end
            endcase
          end
        end
        SQ_WR_PRE:  state_q <= SQ_EXEC;
        SQ_EXEC: begin
          if (exec_end) state_q <= post_q ? SQ_WR_POST : SQ_IDLE;
        end
        SQ_WR_POST: state_q <= SQ_IDLE;
        default:    state_q <= SQ_IDLE;
      endcase
    end
  end

  assign slot_req = (state_q == SQ_EXEC);
  assign rf_we    = write_slot && (tgt_q != '0);
  assign rf_waddr = tgt_q;
  assign rf_wdata = data_q;
  assign busy     = (state_q != SQ_IDLE);

  p_pre_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (cls == HZ_NONE || cls == HZ_WR) && (ld_tgt != '0) |=> rf_we && !slot_req);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && slot_req));

  p_read_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (cls == HZ_RD) |=> slot_req && !rf_we);

  p_post_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && slot_done && post_q && (tgt_q != '0) |=> rf_we);

  p_discard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (cls == HZ_RW) |=> slot_req);

  p_discard_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && slot_done && !post_q |=> !rf_we && !busy);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ld_valid |=> $stable(rf_waddr) && $stable(rf_wdata));

  p_no_r0_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != '0));

endmodule

// File: rtl/ldslot_hazard_unit.sv
module ldslot_hazard_unit
  import ldh_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [4:0]        ld_tgt,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [31:0]       slot_insn,
  input  logic              slot_done,
  output logic [1:0]        hz_class,
  output logic              slot_req,
  output logic              rf_we,
  output logic [4:0]        rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              busy
);

  hz_class_e cls_w;

  ldh_classify u_classify (
    .tgt  (ld_tgt),
    .insn (slot_insn),
    .cls  (cls_w)
  );

  assign hz_class = cls_w;

  ldh_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_tgt    (ld_tgt),
    .ld_data   (ld_data),
    .cls       (cls_w),
    .slot_done (slot_done),
    .slot_req  (slot_req),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .rf_wdata  (rf_wdata),
    .busy      (busy)
  );

  p_zero_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_tgt == 5'd0) |-> (hz_class == 2'd0));

  p_nop_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_insn == 32'd0) |-> (hz_class == 2'd0));

endmodule

// File: tb/ldslot_hazard_unit_bench.sv
module ldslot_hazard_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid;
  logic [4:0]  ld_tgt;
  logic [31:0] ld_data;
  logic [31:0] slot_insn;
  logic        slot_done;
  logic [1:0]  hz_class;
  logic        slot_req;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ldslot_hazard_unit #(.DATA_W(32)) u_ldslot_hazard_unit (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_tgt(ld_tgt),
    .ld_data(ld_data), .slot_insn(slot_insn), .slot_done(slot_done),
    .hz_class(hz_class), .slot_req(slot_req), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .busy(busy)
  );

  function automatic logic [31:0] rtype(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt);
    return {op, rs, rt, 16'h1234};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cls_case(input string req, input logic [4:0] tgt,
                          input logic [31:0] w, input logic [1:0] exp);
    @(posedge clk); #1;
    ld_valid = 1'b0; ld_tgt = tgt; slot_insn = w;
    #1 chk(req, {30'd0, hz_class}, {30'd0, exp});
  endtask

  // Class 0 or 3: write first, then the slot request.
  task automatic seq_pre(input string req, input logic [4:0] tgt,
                         input logic [31:0] w, input logic [31:0] data);
    @(posedge clk); #1;
    ld_valid = 1'b1; ld_tgt = tgt; slot_insn = w; ld_data = data;
    @(posedge clk); #1;
    ld_valid = 1'b0;
    chk({req, " we"}, rf_we, (tgt != 5'd0));
    if (tgt != 5'd0) begin
      chk({req, " waddr"}, rf_waddr, tgt);
      chk({req, " wdata"}, rf_wdata, data);
    end
    chk({req, " no req yet"}, slot_req, 1'b0);
    @(posedge clk); #1;
    chk({req, " req"}, slot_req, 1'b1);
    chk({req, " no we in exec"}, rf_we, 1'b0);
    slot_done = 1'b1;
    @(posedge clk); #1;
    slot_done = 1'b0;
    chk({req, " idle"}, busy, 1'b0);
    chk({req, " no late we"}, rf_we, 1'b0);
  endtask

  // Class 2: slot request first, write after the handshake.
  task automatic seq_read(input string req, input logic [4:0] tgt,
                          input logic [31:0] w, input logic [31:0] data, input bit intrude);
    @(posedge clk); #1;
    ld_valid = 1'b1; ld_tgt = tgt; slot_insn = w; ld_data = data;
    @(posedge clk); #1;
    ld_valid = 1'b0;
    chk({req, " req first"}, slot_req, 1'b1);
    chk({req, " no early we"}, rf_we, 1'b0);
    slot_done = 1'b1;
    if (intrude) begin
      ld_valid = 1'b1; ld_tgt = tgt + 5'd1; ld_data = ~data; slot_insn = 32'd0;
    end
    @(posedge clk); #1;
    slot_done = 1'b0; ld_valid = 1'b0;
    chk({req, " post we"}, rf_we, 1'b1);
    chk({req, " post waddr"}, rf_waddr, tgt);
    chk({req, " post wdata"}, rf_wdata, data);
    chk({req, " req dropped"}, slot_req, 1'b0);
    @(posedge clk); #1;
    chk({req, " idle"}, busy, 1'b0);
    chk({req, " single we"}, rf_we, 1'b0);
  endtask

  // Class 1: slot request only, no write.
  task automatic seq_discard(input string req, input logic [4:0] tgt,
                             input logic [31:0] w, input logic [31:0] data);
    @(posedge clk); #1;
    ld_valid = 1'b1; ld_tgt = tgt; slot_insn = w; ld_data = data;
    @(posedge clk); #1;
    ld_valid = 1'b0;
    chk({req, " req"}, slot_req, 1'b1);
    chk({req, " no we"}, rf_we, 1'b0);
    slot_done = 1'b1;
    @(posedge clk); #1;
    slot_done = 1'b0;
    chk({req, " idle"}, busy, 1'b0);
    chk({req, " dropped"}, rf_we, 1'b0);
    @(posedge clk); #1;
    chk({req, " still no we"}, rf_we, 1'b0);
  endtask

  task automatic t_reset;
    chk("R9 reset busy", busy, 1'b0);
    chk("R9 reset we", rf_we, 1'b0);
    chk("R9 reset req", slot_req, 1'b0);
  endtask

  task automatic t_special;
    cls_case("R1 target zero", 5'd0, rtype(5'd0, 5'd0, 5'd0, 6'h21), 2'd0);
    cls_case("R1 target zero lui", 5'd0, itype(6'h0F, 5'd0, 5'd0), 2'd0);
    cls_case("R2 zero word", 5'd5, 32'd0, 2'd0);
    cls_case("R3 rw", 5'd5, rtype(5'd5, 5'd2, 5'd5, 6'h21), 2'd1);
    cls_case("R3 read", 5'd5, rtype(5'd3, 5'd5, 5'd7, 6'h21), 2'd2);
    cls_case("R3 write", 5'd5, rtype(5'd1, 5'd2, 5'd5, 6'h21), 2'd3);
    cls_case("R3 none", 5'd5, rtype(5'd1, 5'd2, 5'd3, 6'h21), 2'd0);
    cls_case("R4 const shift ignores rs", 5'd5, rtype(5'd5, 5'd9, 5'd4, 6'h00), 2'd0);
    cls_case("R4 const shift rw", 5'd5, rtype(5'd0, 5'd5, 5'd5, 6'h02), 2'd1);
    cls_case("R4 var shift rs", 5'd5, rtype(5'd5, 5'd1, 5'd6, 6'h04), 2'd2);
    cls_case("R4 slt rt", 5'd5, rtype(5'd1, 5'd5, 5'd6, 6'h2A), 2'd2);
    cls_case("R4 jr", 5'd5, rtype(5'd5, 5'd0, 5'd0, 6'h08), 2'd2);
    cls_case("R4 jalr", 5'd5, rtype(5'd5, 5'd0, 5'd5, 6'h09), 2'd1);
    cls_case("R4 mfhi", 5'd5, rtype(5'd0, 5'd0, 5'd5, 6'h10), 2'd3);
    cls_case("R4 mtlo", 5'd5, rtype(5'd5, 5'd0, 5'd0, 6'h13), 2'd2);
    cls_case("R4 mult", 5'd5, rtype(5'd1, 5'd5, 5'd0, 6'h18), 2'd2);
  endtask

  task automatic t_immediate;
    cls_case("R5 addiu rw", 5'd5, itype(6'h09, 5'd5, 5'd5), 2'd1);
    cls_case("R5 lw write", 5'd5, itype(6'h23, 5'd1, 5'd5), 2'd3);
    cls_case("R5 lui write", 5'd5, itype(6'h0F, 5'd0, 5'd5), 2'd3);
    cls_case("R5 lui rs ignored", 5'd5, itype(6'h0F, 5'd5, 5'd1), 2'd0);
    cls_case("R5 jal link", 5'd31, {6'h03, 26'h0000100}, 2'd3);
    cls_case("R5 jal other", 5'd5, {6'h03, 26'h0000100}, 2'd0);
    cls_case("R6 lwl both", 5'd5, itype(6'h22, 5'd5, 5'd5), 2'd3);
    cls_case("R6 lwr rs only", 5'd5, itype(6'h26, 5'd5, 5'd1), 2'd2);
    cls_case("R7 sw rt", 5'd5, itype(6'h2B, 5'd1, 5'd5), 2'd2);
    cls_case("R7 beq rs", 5'd5, itype(6'h04, 5'd5, 5'd2), 2'd2);
    cls_case("R7 bgtz", 5'd5, itype(6'h07, 5'd5, 5'd0), 2'd2);
    cls_case("R7 regimm", 5'd5, itype(6'h01, 5'd5, 5'h10), 2'd2);
    cls_case("R7 swc2", 5'd5, itype(6'h3A, 5'd5, 5'd5), 2'd2);
  endtask

  task automatic t_copro;
    cls_case("R8 mfc0", 5'd5, {6'h10, 5'h00, 5'd5, 16'h4000}, 2'd3);
    cls_case("R8 ctc2", 5'd5, {6'h12, 5'h06, 5'd5, 16'h0000}, 2'd2);
    cls_case("R8 cop2 command", 5'd5, {6'h12, 1'b1, 4'h0, 5'd5, 16'h0001}, 2'd0);
  endtask

  task automatic t_sequences;
    seq_pre("R9 none path", 5'd5, 32'd0, 32'hA5A5_0001);
    seq_pre("R9 write path", 5'd5, itype(6'h23, 5'd1, 5'd5), 32'h1111_2222);
    seq_read("R10 read path", 5'd5, itype(6'h2B, 5'd1, 5'd5), 32'hCAFE_0003, 1'b0);
    seq_discard("R11 rw path", 5'd5, itype(6'h09, 5'd5, 5'd5), 32'hDEAD_0004);
    seq_read("R12 busy ignores load", 5'd7, itype(6'h04, 5'd7, 5'd2), 32'h0BAD_F00D, 1'b1);
    seq_pre("R13 reg zero", 5'd0, rtype(5'd0, 5'd0, 5'd0, 6'h21), 32'h7777_7777);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ld_valid = 1'b0; ld_tgt = '0; ld_data = '0;
    slot_insn = '0; slot_done = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 t_reset();
    t_special();
    t_immediate();
    t_copro();
    t_sequences();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule